// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block is the sending half of a clock-synchronous serial port. A processor writes a byte into a holding register. When transmission is enabled and no overrun error is pending, the byte moves into an 8-bit shift register and goes out least significant bit first. While that frame is on the wire, the holding register is free for the next byte. A byte that is waiting when a frame finishes starts the next frame with no idle time.

As master, the block drives the serial clock from an integer divider of the system clock and drives the data line. As slave, it drives only the data line and follows an external serial clock, which it samples through a synchronizer. Clock idle polarity and data phase are selectable.

Two flags are visible to software: a holding-register-empty flag and a transmit-end flag. Each flag has an interrupt output gated by its own enable.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `empty_flag` is 1, `end_flag` is 0 and `irq_end` is 0. `sck_oe` equals `master`. One cycle after reset is released, `sck_out` equals `cpol`.
- R2: The cycle after a `wr_stb` pulse, `empty_flag` and `end_flag` are both 0. If `tx_en`=1, `ovr_err`=0 and no frame is running, the byte moves into the shift register one cycle later and `empty_flag` returns to 1.
- R3: A frame carries the 8 data bits in order from bit 0 to bit 7, one bit per serial clock period.
- R4: With `cpha`=0, data changes on the odd serial clock edges of a frame (1st, 3rd, ...) and is sampled on the even edges. With `cpha`=1, bit 0 is driven when the frame starts, data changes on the even edges, and data is sampled on the odd edges.
- R5: As master (`master`=1), `sck_oe` is 1 and `sck_out` idles at `cpol`. Every half period lasts max(`half_div`,1) system clocks. After the 16th edge of the last frame, `sck_out` rests at `cpol`. As slave, `sck_oe` is 0.
- R6: As slave, each edge of `sck_in` advances the frame, after a two-stage synchronizer. Edges that arrive while no frame is running are ignored.
- R7: If a byte is waiting in the holding register when the 16th edge of a frame occurs, the next frame starts at once. Its first edge follows exactly one half period later.
- R8: `end_flag` becomes 1 when the 16th edge occurs while `empty_flag` is 1. It stays 1 until the next `wr_stb`.
- R9: `irq_empty` = `empty_flag` AND `ie_empty`. `irq_end` = `end_flag` AND `ie_end`.
- R10: While `ovr_err` is 1, no frame starts. The written byte stays held with `empty_flag` at 0, and it is sent once `ovr_err` returns to 0.
- R11: While `tx_en` is 0, no frame starts and a written byte stays pending. The byte is sent after `tx_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| master | input | 1 | 1: drive the serial clock; 0: follow `sck_in` |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Data phase select (see R4) |
| half_div | input | DIV_W | System clocks per serial half period (0 treated as 1) |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| ovr_err | input | 1 | Pending overrun error; blocks transmission |
| ie_empty | input | 1 | Interrupt enable for holding-register-empty |
| ie_end | input | 1 | Interrupt enable for transmit-end |
| sck_in | input | 1 | External serial clock in slave mode |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sdo | output | 1 | Serial data out |
| empty_flag | output | 1 | Holding register is empty |
| end_flag | output | 1 | Transmission ended with nothing waiting |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case to produce is the seamless hand-off. The next byte has to be in the holding register before the 16th edge, so that the reload and the first edge of the new frame fall exactly one half period apart. The stimulus writes each further byte as soon as `empty_flag` rises after a load, including with the fastest divider, and the bench times every serial clock interval across the whole burst. Slave bursts use the same write pattern while the bench paces `sck_in` itself, so the reload happens while the synchronizer is still settling.

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovr_err,
  input  logic              ie_empty,
  input  logic              ie_end,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES);

  logic [DATA_W-1:0]      hold_q, shf_q;
  logic                   empty_q, end_q, active_q, sck_q, sdo_q, slv_prev_q;
  logic [EDGE_W-1:0]      edge_q;
  logic [DIV_W-1:0]       hcnt_q;
  logic [SYNC_STAGES-1:0] sync_q;

  logic [DIV_W-1:0]  half_eff;
  logic [EDGE_W-1:0] edge_nx;
  logic hit, slv_edge, tick, last, can_go, start, reload, chg;

  assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign hit      = hcnt_q == half_eff - DIV_W'(1);
  assign slv_edge = sync_q[SYNC_STAGES-1] ^ slv_prev_q;
  assign tick     = active_q & (master ? hit : slv_edge);
  assign edge_nx  = edge_q + EDGE_W'(1);
  assign last     = tick && (edge_nx == LAST_EDGE);
  assign can_go   = tx_en && !ovr_err && !empty_q;
  assign start    = !active_q && can_go;
  assign reload   = last && can_go;
  assign chg      = cpha ? (!edge_nx[0] && !last) : edge_nx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      shf_q      <= '0;
      empty_q    <= 1'b1;
      end_q      <= 1'b0;
      active_q   <= 1'b0;
      sck_q      <= 1'b1;
      sdo_q      <= 1'b1;
      slv_prev_q <= 1'b0;
      edge_q     <= '0;
      hcnt_q     <= '0;
      sync_q     <= '0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], sck_in};
      slv_prev_q <= sync_q[SYNC_STAGES-1];
      if (active_q && master) hcnt_q <= hit ? '0 : hcnt_q + DIV_W'(1);
      if (!active_q) sck_q <= cpol;
      if (tick) begin
        edge_q <= edge_nx;
        if (master) sck_q <= ~sck_q;
        if (chg) begin
          sdo_q <= shf_q[0];
          shf_q <= shf_q >> 1;
        end
      end
      if (start || reload) begin
        active_q <= 1'b1;
        edge_q   <= '0;
        hcnt_q   <= '0;
        empty_q  <= 1'b1;
        if (cpha) begin
          sdo_q <= hold_q[0];
          shf_q <= hold_q >> 1;
        end else begin
          shf_q <= hold_q;
        end
      end else if (last) begin
        active_q <= 1'b0;
        edge_q   <= '0;
        if (empty_q) end_q <= 1'b1;
      end
      if (wr_stb) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
        end_q   <= 1'b0;
      end
    end
  end

  assign sck_out    = sck_q;
  assign sck_oe     = master;
  assign sdo        = sdo_q;
  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign irq_empty  = empty_q & ie_empty;
  assign irq_end    = end_q & ie_end;

  assert_wr_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (!empty_flag && !end_flag));
  assert_empty_fall_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_flag) |-> $past(wr_stb));
  assert_ovr_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && ovr_err) |=> !active_q);
  assert_en_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !tx_en) |=> !active_q);
  assert_end_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> empty_flag);
  assert_sck_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(end_flag) && master) |-> (sck_out == cpol));
  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (edge_q < LAST_EDGE));
endmodule

// File: tb/sync_ser_tx_tb.sv
module sync_ser_tx_tb;
  logic clk = 0, rst_n = 0;
  logic tx_en = 1, master = 1, cpol = 1, cpha = 0;
  logic [7:0] half_div = 8'd2;
  logic wr_stb = 0;
  logic [7:0] wr_data = 0;
  logic ovr_err = 0, ie_empty = 1, ie_end = 1, sck_in_r = 1;
  logic sck_out, sck_oe, sdo, empty_flag, end_flag, irq_empty, irq_end;

  sync_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .master(master), .cpol(cpol), .cpha(cpha),
    .half_div(half_div), .wr_stb(wr_stb), .wr_data(wr_data), .ovr_err(ovr_err),
    .ie_empty(ie_empty), .ie_end(ie_end), .sck_in(sck_in_r), .sck_out(sck_out),
    .sck_oe(sck_oe), .sdo(sdo), .empty_flag(empty_flag), .end_flag(end_flag),
    .irq_empty(irq_empty), .irq_end(irq_end));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  localparam int SLV_HALF = 5;

  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] rx_sh;
  int edge_no, nsamp, edge_total, tim_err, cyc, last_cyc;
  bit had_edge, prev_line, line;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    line = master ? sck_out : sck_in_r;
    if (line != prev_line) begin
      edge_total++;
      edge_no++;
      if (master) begin
        if (had_edge && (cyc - last_cyc) != ((half_div == 0) ? 1 : int'(half_div))) tim_err++;
        had_edge = 1;
        last_cyc = cyc;
      end
      if (cpha ? (edge_no % 2 == 1) : (edge_no % 2 == 0)) begin
        rx_sh = {sdo, rx_sh[7:1]};
        nsamp++;
        if (nsamp == 8) begin
          rx_q.push_back(rx_sh);
          nsamp = 0;
        end
      end
      if (edge_no == 16) edge_no = 0;
    end
    prev_line = line;
  end

  task automatic mon_clr();
    edge_no = 0; nsamp = 0; edge_total = 0; tim_err = 0; had_edge = 0;
    rx_q.delete(); exp_q.delete();
    prev_line = master ? sck_out : sck_in_r;
  endtask

  task automatic setup(input bit m, input bit pol, input bit pha, input int dv);
    @(negedge clk);
    master = m; cpol = pol; cpha = pha; half_div = 8'(dv); sck_in_r = pol;
    repeat (4) @(negedge clk);
    #2 mon_clr();
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_stb = 1; wr_data = b;
    @(negedge clk);
    wr_stb = 0;
    exp_q.push_back(b);
  endtask

  task automatic slave_edges(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (SLV_HALF) @(negedge clk);
      #1 sck_in_r = ~sck_in_r;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_end();
    for (int k = 0; k < 5000 && !end_flag; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare_frames(input string req);
    check(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      check(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
  endtask

  task automatic burst(input int n);
    write_byte(8'($urandom));
    if (master) begin
      for (int i = 1; i < n; i++) begin
        while (!empty_flag) @(negedge clk);
        write_byte(8'($urandom));
      end
      wait_end();
    end else begin
      repeat (3) @(negedge clk);
      for (int i = 0; i < n; i++) begin
        if (i + 1 < n) write_byte(8'($urandom));
        slave_edges(16);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(empty_flag == 1, "R1 empty", empty_flag, 1);
    check(end_flag == 0, "R1 end", end_flag, 0);
    check(sck_out == cpol, "R1 sck idle", sck_out, cpol);
    check(sck_oe == 1, "R1 sck_oe", sck_oe, 1);
    check(irq_end == 0, "R1 irq_end", irq_end, 0);
    check(irq_empty == 1, "R9 irq_empty at reset", irq_empty, 1);

    // R2 empty flag sequencing
    setup(1, 1, 0, 2);
    @(negedge clk); wr_stb = 1; wr_data = 8'hA5;
    @(negedge clk); wr_stb = 0; exp_q.push_back(8'hA5);
    check(empty_flag == 0, "R2 empty after write", empty_flag, 0);
    @(negedge clk);
    check(empty_flag == 1, "R2 empty after load", empty_flag, 1);
    wait_end();
    compare_frames("R3 single frame");
    check(sck_out == cpol, "R5 sck rests at cpol", sck_out, cpol);
    check(end_flag == 1, "R8 end set", end_flag, 1);

    // R8 hold, R9 gating
    repeat (30) @(negedge clk);
    check(end_flag == 1, "R8 end held", end_flag, 1);
    ie_end = 0; @(negedge clk);
    check(irq_end == 0, "R9 irq_end masked", irq_end, 0);
    ie_end = 1; ie_empty = 0; @(negedge clk);
    check(irq_end == 1, "R9 irq_end raised", irq_end, 1);
    check(irq_empty == 0, "R9 irq_empty masked", irq_empty, 0);
    ie_empty = 1;

    // R11 tx_en blocks start; write clears end (R2)
    setup(1, 0, 1, 3);
    tx_en = 0;
    write_byte(8'h3C);
    check(end_flag == 0, "R2 write clears end", end_flag, 0);
    repeat (40) @(negedge clk);
    check(empty_flag == 0, "R11 byte pending", empty_flag, 0);
    check(edge_total == 0, "R11 no clock edges", edge_total, 0);
    tx_en = 1;
    wait_end();
    compare_frames("R11 sent after enable");

    // R10 overrun blocks start
    setup(1, 1, 1, 1);
    ovr_err = 1;
    write_byte(8'hC3);
    repeat (40) @(negedge clk);
    check(empty_flag == 0, "R10 byte held", empty_flag, 0);
    check(edge_total == 0, "R10 no clock edges", edge_total, 0);
    ovr_err = 0;
    wait_end();
    compare_frames("R10 sent after clear");

    // R7 back-to-back at fastest divider, R4 both phases
    for (int p = 0; p < 2; p++) begin
      setup(1, 0, 1'(p), 0);
      burst(3);
      compare_frames("R7 R4 burst data");
      check(tim_err == 0, "R7 gapless timing", tim_err, 0);
      check(edge_total == 48, "R3 edge count", edge_total, 48);
    end

    // R6 slave directed
    setup(0, 0, 1, 2);
    check(sck_oe == 0, "R5 slave oe", sck_oe, 0);
    slave_edges(4);
    check(edge_total == 4 && empty_flag == 1, "R6 idle edges ignored", empty_flag, 1);
    #2 mon_clr();
    burst(2);
    compare_frames("R6 slave burst");
    check(end_flag == 1, "R8 slave end", end_flag, 1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      setup(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 5));
      ie_end = 1'($urandom);
      burst(1 + int'($urandom % 3));
      compare_frames("R3 R4 random data");
      if (master) check(tim_err == 0, "R5 half period", tim_err, 0);
      if (master) check(sck_out == cpol, "R5 rest level", sck_out, cpol);
      check(end_flag == 1, "R8 random end", end_flag, 1);
      check(irq_end == ie_end, "R9 random irq_end", irq_end, ie_end);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule